// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregator

This block gathers single-cycle interrupt request pulses from peripherals into two 32-bit sticky status banks. Each bank has its own enable mask. A bit is pending when its status bit and its mask bit are both 1. The pending bits of both banks are ORed together, bit by bit, and two active-low lines to the processor are driven from the result. Bit 0 drives the fast line. Bits 1 to 15 drive the normal line. Bits 16 to 31 can be latched and masked, but they drive neither line.

Software reaches the block through a simple register bus. The bus has an access strobe, a write enable, an address, write data and combinational read data. Each bank has three registers:

- A status register. Reading it returns the bank and clears it in the same access.
- An enable register. Writing it replaces the mask. Reading it returns the mask.
- An enable-toggle register. Writing it flips every mask bit that is 1 in the written word.

The two lines follow the registered status and mask with no added cycle.

Top module: `irqagg_top`

## Requirements
- R1: After synchronous reset, both status banks and both masks are zero, and both interrupt lines are high.
- R2: A 1 on a bit of `src_set` (bank k occupies bits k*32 to k*32+31) sets that status bit at the next edge. The bit stays set until its bank's status register is read.
- R3: The address is {bank, function}, with function 0 = status, 1 = enable, 2 = toggle and 3 = reserved. A read of function 0 returns the bank's status and clears the bank at that edge. Set pulses in the same cycle are still recorded.
- R4: A write to function 1 replaces that bank's mask with the written data. A read of function 1 returns the current mask.
- R5: A write to function 2 XORs that bank's mask with the written data.
- R6: `fast_irq_n` is low exactly when bit 0 of (status0 & mask0) | (status1 & mask1) is 1.
- R7: `norm_irq_n` is low exactly when any of bits 1 to 15 of that combined pending set is 1.
- R8: Pending bits 16 to 31 leave both lines high.
- R9: Writes to function 0 or 3 leave status and mask unchanged. Reads of function 2 or 3 return zero and change nothing. With `bus_req` low, nothing changes and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | {bank, function[1:0]} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| src_set | input | 64 | Per-source set pulses, bank 1 in the upper half |
| fast_irq_n | output | 1 | Active-low fast interrupt |
| norm_irq_n | output | 1 | Active-low normal interrupt |

## Verification
The assertions take for granted that `bus_req`, `bus_we` and `bus_addr` are never X while out of reset. They also assume that a single cycle carries at most one register access, so one bank sees at most one of read-clear, mask replace and mask toggle per edge. The bench drives exactly one access, or none, per cycle, and always with defined values. Set pulses are allowed to coincide with any access, including a status read of the same bank. That is the case the read-clear rule must survive.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int unsigned IRQ_BANKS  = 2;
    localparam int unsigned IRQ_WIDTH  = 32;
    localparam int unsigned BANK_SEL_W = (IRQ_BANKS > 1) ? $clog2(IRQ_BANKS) : 1;
    localparam int unsigned FN_W       = 2;
    localparam int unsigned IRQ_ADDR_W = BANK_SEL_W + FN_W;

    typedef enum logic [FN_W-1:0] {
        FN_STATUS = 2'd0,
        FN_ENABLE = 2'd1,
        FN_TOGGLE = 2'd2,
        FN_RSVD   = 2'd3
    } reg_fn_e;

    typedef struct packed {
        logic                  rd;
        logic                  wr;
        logic [BANK_SEL_W-1:0] bank;
        reg_fn_e               fn;
    } access_t;

    function automatic access_t split_access(input logic req, input logic we,
                                             input logic [IRQ_ADDR_W-1:0] addr);
        access_t a;
        a.rd   = req & ~we;
        a.wr   = req & we;
        a.bank = addr[IRQ_ADDR_W-1:FN_W];
        a.fn   = reg_fn_e'(addr[FN_W-1:0]);
        return a;
    endfunction

endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = IRQ_BANKS,
    parameter int unsigned ADDR_W    = IRQ_ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    output access_t              acc,
    output logic [NUM_BANKS-1:0] rd_stat,
    output logic [NUM_BANKS-1:0] wr_mask,
    output logic [NUM_BANKS-1:0] tog_mask
);

    assign acc = split_access(req, we, addr);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
        logic hit;
        assign hit         = (acc.bank == BANK_SEL_W'(b));
        assign rd_stat[b]  = hit & acc.rd & (acc.fn == FN_STATUS);
        assign wr_mask[b]  = hit & acc.wr & (acc.fn == FN_ENABLE);
        assign tog_mask[b] = hit & acc.wr & (acc.fn == FN_TOGGLE);
    end

    // R9: one access touches at most one bank operation
    assert_single_op_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_stat, wr_mask, tog_mask}));

    // R9: an idle bus strobes nothing
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !req |-> ({rd_stat, wr_mask, tog_mask} == '0));

endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic             rd_stat,
    input  logic             wr_mask,
    input  logic             tog_mask,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] status_q,
    output logic [WIDTH-1:0] mask_q
);

    logic [WIDTH-1:0] status_keep;
    logic [WIDTH-1:0] status_d;
    logic [WIDTH-1:0] mask_d;

    assign status_keep = rd_stat ? '0 : status_q;
    assign status_d    = status_keep | set_i;

    always_comb begin
        mask_d = mask_q;
        if (wr_mask)       mask_d = wdata;
        else if (tog_mask) mask_d = mask_q ^ wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
        end
    end

    assert_set_latched_R2: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

    assert_read_clear_R3: assert property (@(posedge clk) disable iff (rst)
        rd_stat |=> (status_q == $past(set_i)));

    assert_mask_replace_R4: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> (mask_q == $past(wdata)));

    assert_mask_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        tog_mask |=> (mask_q == ($past(mask_q) ^ $past(wdata))));

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr_mask && !tog_mask) |=> $stable(mask_q));

endmodule

// File: rtl/irqagg_route.sv
module irqagg_route #(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned WIDTH     = 32,
    parameter int unsigned FAST_BIT  = 0,
    parameter int unsigned NORM_LO   = 1,
    parameter int unsigned NORM_HI   = 15
) (
    input  logic [NUM_BANKS-1:0][WIDTH-1:0] status,
    input  logic [NUM_BANKS-1:0][WIDTH-1:0] mask,
    output logic [WIDTH-1:0]                pend_o,
    output logic                            fast_n,
    output logic                            norm_n
);

    logic [NUM_BANKS:0][WIDTH-1:0] acc;

    assign acc[0] = '0;
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_or
        assign acc[b+1] = acc[b] | (status[b] & mask[b]);
    end

    assign pend_o = acc[NUM_BANKS];
    assign fast_n = ~pend_o[FAST_BIT];
    assign norm_n = ~(|pend_o[NORM_HI:NORM_LO]);

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = IRQ_BANKS,
    parameter int unsigned DATA_W    = IRQ_WIDTH,
    parameter int unsigned FAST_BIT  = 0,
    parameter int unsigned NORM_LO   = 1,
    parameter int unsigned NORM_HI   = 15,
    localparam int unsigned ADDR_W   = IRQ_ADDR_W,
    localparam int unsigned SET_W    = NUM_BANKS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SET_W-1:0]  src_set,
    output logic              fast_irq_n,
    output logic              norm_irq_n
);

    access_t                            acc;
    logic [NUM_BANKS-1:0]               rd_stat;
    logic [NUM_BANKS-1:0]               wr_mask;
    logic [NUM_BANKS-1:0]               tog_mask;
    logic [NUM_BANKS-1:0][DATA_W-1:0]   stat_w;
    logic [NUM_BANKS-1:0][DATA_W-1:0]   mask_w;
    logic [DATA_W-1:0]                  pend_w;

    irqagg_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_decode (
        .clk      (clk),
        .rst      (rst),
        .req      (bus_req),
        .we       (bus_we),
        .addr     (bus_addr),
        .acc      (acc),
        .rd_stat  (rd_stat),
        .wr_mask  (wr_mask),
        .tog_mask (tog_mask)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irqagg_bank #(.WIDTH(DATA_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .set_i    (src_set[b*DATA_W +: DATA_W]),
            .rd_stat  (rd_stat[b]),
            .wr_mask  (wr_mask[b]),
            .tog_mask (tog_mask[b]),
            .wdata    (bus_wdata),
            .status_q (stat_w[b]),
            .mask_q   (mask_w[b])
        );
    end

    irqagg_route #(
        .NUM_BANKS (NUM_BANKS),
        .WIDTH     (DATA_W),
        .FAST_BIT  (FAST_BIT),
        .NORM_LO   (NORM_LO),
        .NORM_HI   (NORM_HI)
    ) u_route (
        .status (stat_w),
        .mask   (mask_w),
        .pend_o (pend_w),
        .fast_n (fast_irq_n),
        .norm_n (norm_irq_n)
    );

    always_comb begin
        bus_rdata = '0;
        if (acc.rd) begin
            case (acc.fn)
                FN_STATUS: bus_rdata = stat_w[acc.bank];
                FN_ENABLE: bus_rdata = mask_w[acc.bank];
                default:   bus_rdata = '0;
            endcase
        end
    end

    // Checks relating bank state to the lines, independent of the route netlist
    logic fast_exp;
    logic norm_exp;
    always_comb begin
        fast_exp = 1'b0;
        norm_exp = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            fast_exp = fast_exp | (stat_w[b][FAST_BIT] & mask_w[b][FAST_BIT]);
            for (int i = NORM_LO; i <= NORM_HI; i++)
                norm_exp = norm_exp | (stat_w[b][i] & mask_w[b][i]);
        end
    end

    assert_fast_line_R6: assert property (@(posedge clk) disable iff (rst)
        fast_irq_n == !fast_exp);

    assert_norm_line_R7: assert property (@(posedge clk) disable iff (rst)
        norm_irq_n == !norm_exp);

    assert_high_bits_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (pend_w[NORM_HI:0] == '0) |-> (fast_irq_n && norm_irq_n));

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (fast_irq_n && norm_irq_n && stat_w == '0 && mask_w == '0));

endmodule

// File: tb/irqagg_top_tb_top.sv
module irqagg_top_tb_top;

    localparam int unsigned W = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_set = '0;
    logic        fast_irq_n;
    logic        norm_irq_n;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_st [2];
    logic [31:0] m_mk [2];

    always #10 clk = ~clk;

    irqagg_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .src_set    (src_set),
        .fast_irq_n (fast_irq_n),
        .norm_irq_n (norm_irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pend();
        return (m_st[0] & m_mk[0]) | (m_st[1] & m_mk[1]);
    endfunction

    task automatic check_lines();
        logic [31:0] p;
        p = pend();
        chk("R6 fast line", {31'd0, fast_irq_n}, {31'd0, ~p[0]});
        chk("R7 normal line", {31'd0, norm_irq_n}, {31'd0, ~(|p[15:1])});
    endtask

    // one bus cycle: drive at negedge, check read data, update model at edge
    task automatic step(input logic req, input logic we, input int b, input int f,
                        input logic [31:0] wd, input logic [63:0] set, input string rtag);
        logic [31:0] exp_rd;
        @(negedge clk);
        bus_req   = req;
        bus_we    = we;
        bus_addr  = {b[0], f[1:0]};
        bus_wdata = wd;
        src_set   = set;
        #2;
        exp_rd = '0;
        if (req && !we) begin
            if (f == 0) exp_rd = m_st[b];
            else if (f == 1) exp_rd = m_mk[b];
            chk(rtag, bus_rdata, exp_rd);
        end else begin
            chk("R9 idle rdata", bus_rdata, 32'd0);
        end
        @(posedge clk);
        if (req && !we && f == 0) m_st[b] = '0;
        m_st[0] = m_st[0] | set[31:0];
        m_st[1] = m_st[1] | set[63:32];
        if (req && we && f == 1) m_mk[b] = wd;
        if (req && we && f == 2) m_mk[b] = m_mk[b] ^ wd;
        #2;
        bus_req = 1'b0;
        src_set = '0;
        check_lines();
    endtask

    initial begin : watchdog
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        m_st[0] = '0; m_st[1] = '0; m_mk[0] = '0; m_mk[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 fast high", {31'd0, fast_irq_n}, 32'd1);
        chk("R1 norm high", {31'd0, norm_irq_n}, 32'd1);
        for (int b = 0; b < 2; b++) begin
            step(1, 0, b, 1, 0, 0, "R1 mask zero");
            step(1, 0, b, 0, 0, 0, "R1 status zero");
        end

        // single-bit sweep over both banks
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 32; i++) begin
                logic [31:0] bit_v;
                logic [63:0] set_v;
                bit_v = 32'd1 << i;
                set_v = (b == 0) ? {32'd0, bit_v} : {bit_v, 32'd0};
                step(1, 1, b, 1, bit_v, 0, "R4");
                step(1, 0, b, 1, 0, 0, "R4 mask readback");
                step(0, 0, 0, 0, 0, set_v, "R2");
                if (i == 0)
                    chk("R6 bit0 fast", {31'd0, fast_irq_n}, 32'd0);
                else if (i <= 15)
                    chk("R7 low bit normal", {31'd0, norm_irq_n}, 32'd0);
                else
                    chk("R8 high bit silent", {30'd0, fast_irq_n, norm_irq_n}, 32'd3);
                step(0, 0, 0, 0, 0, 0, "R2");
                step(1, 0, b, 0, 0, 0, "R3 status read");
                step(1, 0, b, 0, 0, 0, "R3 cleared");
                step(1, 1, b, 1, 0, 0, "R4");
            end
        end

        // cross-bank OR and toggle patterns
        step(1, 1, 0, 1, 32'h0000_00F1, 0, "R4");
        step(1, 1, 1, 1, 32'h0001_0006, 0, "R4");
        step(0, 0, 0, 0, 0, 64'h0000_0001_0000_0000, "R6 other bank");
        step(0, 0, 0, 0, 0, 64'h0000_0000_0000_0001, "R6");
        step(1, 1, 1, 2, 32'hFFFF_0003, 0, "R5 toggle");
        step(1, 0, 1, 1, 0, 0, "R5 readback");
        step(1, 1, 0, 2, 32'h0000_0001, 0, "R5 toggle bank0");
        step(1, 0, 0, 1, 0, 0, "R5 readback bank0");
        step(1, 1, 0, 2, 32'h0000_0001, 0, "R5 toggle back");

        // read-clear with coincident set pulse
        step(0, 0, 0, 0, 0, 64'h0000_0000_0000_00F0, "R2");
        step(1, 0, 0, 0, 0, 64'h0000_0000_0000_0102, "R3 read with set");
        step(1, 0, 0, 0, 0, 0, "R3 survivors");
        step(1, 0, 0, 0, 0, 0, "R3 empty");

        // ignored accesses
        step(0, 0, 0, 0, 0, 64'h0000_0004_0000_0008, "R2");
        step(1, 1, 0, 0, 32'hFFFF_FFFF, 0, "R9");
        step(1, 1, 1, 3, 32'hFFFF_FFFF, 0, "R9");
        step(1, 0, 0, 2, 0, 0, "R9 toggle reads zero");
        step(1, 0, 1, 3, 0, 0, "R9 reserved reads zero");
        step(1, 0, 0, 1, 0, 0, "R9 mask unchanged");
        step(1, 0, 1, 1, 0, 0, "R9 mask unchanged");
        step(1, 0, 0, 0, 0, 0, "R9 status unchanged");
        step(1, 0, 1, 0, 0, 0, "R9 status unchanged");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule